// File: doc/BRIEF.md
# Two-Stage Interrupt Priority Selector

This block looks at a set of interrupt sources and names the one that should be served next. Each source has a pending bit and a priority number. A smaller number is more favoured. The block reports whether any source qualifies, which source won and what priority it carries.

The selection uses two reductions instead of a chain of comparators. The first stage builds an occupancy vector with one bit per priority level. A bit is set when some pending source sits at that level. A find-lowest-set-bit encoder then picks the most favoured occupied level. The second stage builds a match vector with one bit per source. A bit is set when that source is pending at the chosen level. The same kind of encoder then picks the lowest-numbered matching source.

The all-ones priority value acts as a per-source mask. The result is registered once. Inputs sampled at one clock edge appear on the outputs right after that edge.

Top module: `irq_prio_select`

## Requirements
- R1: Among pending, unmasked sources, the reported priority `best_prio_o` is the smallest priority number present.
- R2: When several pending, unmasked sources share that smallest priority, `best_src_o` is the lowest source index among them.
- R3: When `found_o` is 1, `best_src_o` names a source that was pending, and `best_prio_o` equals that source's priority field. Source s uses bits `[s*PRIO_W +: PRIO_W]` of `prio_i`.
- R4: A source whose priority field is all ones (7 for PRIO_W=3) is masked. It never wins, and it never makes `found_o` go high.
- R5: When no source is both pending and unmasked, `found_o` is 0, `best_src_o` is 0 and `best_prio_o` is all ones.
- R6: The outputs reflect the inputs sampled at the previous rising clock edge. The latency is exactly one cycle.
- R7: While `rst` is high at a rising edge, the outputs go to the idle values of R5 at that edge.
- R8: A source whose pending bit is 0 has no effect on the result, even when it has a more favoured priority than the winner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | N_SRC | Pending bit per source |
| prio_i | input | N_SRC*PRIO_W | Priority per source, packed; source s at bits [s*PRIO_W +: PRIO_W] |
| found_o | output | 1 | A pending, unmasked source exists |
| best_src_o | output | $clog2(N_SRC) | Index of the winning source |
| best_prio_o | output | PRIO_W | Priority of the winning source |

## Verification
The hardest case is a tie at the best level. Several pending sources share the smallest priority, while lower-numbered sources are pending at worse levels or are masked. Only then does the second-stage encoder have to skip sources that the first stage did not choose. The stimulus reaches this case in two ways. It sweeps every single-source placement and every pair of sources with equal and unequal priorities. It then runs a long pseudo-random pass that draws priorities from only a few levels, so ties and masked fields appear often.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  // Default configuration shared by the selector modules.
  localparam int unsigned DEF_N_SRC  = 16;
  localparam int unsigned DEF_PRIO_W = 3;
endpackage

// File: rtl/irq_lowest_set.sv
// Finds the index of the lowest set bit of a vector.
// Both selection stages use this encoder.
module irq_lowest_set #(
  parameter int unsigned W  = 8,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |vec_i;

  // The chosen bit must be set whenever any bit is set.
  always_comb begin
    if (any_o) a_r2_idx_hits_set_bit: assert (vec_i[idx_o]);
  end
endmodule

// File: rtl/irq_level_occupancy.sv
// Builds one bit per priority level: set when a pending source sits at that level.
// The all-ones level is the mask value and is never marked occupied.
module irq_level_occupancy #(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned PRIO_W = 3,
  localparam int unsigned LEVELS = 1 << PRIO_W
) (
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic [LEVELS-1:0]       occ_o
);
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    if (l == LEVELS - 1) begin : g_mask
      assign occ_o[l] = 1'b0;
    end else begin : g_live
      logic [N_SRC-1:0] hit;
      for (genvar s = 0; s < N_SRC; s++) begin : g_src
        assign hit[s] = pend_i[s] && (prio_i[s*PRIO_W +: PRIO_W] == PRIO_W'(l));
      end
      assign occ_o[l] = |hit;
    end
  end
endmodule

// File: rtl/irq_source_match.sv
// Builds one bit per source: set when the source is pending at the chosen level.
module irq_source_match #(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned PRIO_W = 3
) (
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic                    lvl_ok_i,
  input  logic [PRIO_W-1:0]       lvl_i,
  output logic [N_SRC-1:0]        match_o
);
  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    assign match_o[s] = lvl_ok_i && pend_i[s] &&
                        (prio_i[s*PRIO_W +: PRIO_W] == lvl_i);
  end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_SRC  = DEF_N_SRC,
  parameter int unsigned PRIO_W = DEF_PRIO_W,
  localparam int unsigned LEVELS = 1 << PRIO_W,
  localparam int unsigned SRC_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_SRC-1:0]        pend_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    found_o,
  output logic [SRC_W-1:0]        best_src_o,
  output logic [PRIO_W-1:0]       best_prio_o
);
  logic [LEVELS-1:0] occ;
  logic              lvl_any;
  logic [PRIO_W-1:0] lvl_sel;
  logic [N_SRC-1:0]  match;
  logic              src_any;
  logic [SRC_W-1:0]  src_sel;

  // Stage 1: find the best occupied priority level.
  irq_level_occupancy #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_occ (
    .pend_i(pend_i), .prio_i(prio_i), .occ_o(occ)
  );

  irq_lowest_set #(.W(LEVELS)) u_lvl_enc (
    .vec_i(occ), .any_o(lvl_any), .idx_o(lvl_sel)
  );

  // Stage 2: find the lowest-numbered source pending at that level.
  irq_source_match #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_match (
    .pend_i(pend_i), .prio_i(prio_i), .lvl_ok_i(lvl_any),
    .lvl_i(lvl_sel), .match_o(match)
  );

  irq_lowest_set #(.W(N_SRC)) u_src_enc (
    .vec_i(match), .any_o(src_any), .idx_o(src_sel)
  );

  // Output register; the idle value is also the reset value.
  always_ff @(posedge clk) begin
    if (rst || !src_any) begin
      found_o     <= 1'b0;
      best_src_o  <= '0;
      best_prio_o <= '1;
    end else begin
      found_o     <= 1'b1;
      best_src_o  <= src_sel;
      best_prio_o <= lvl_sel;
    end
  end

  // ---------------- assertions ----------------
  // These registered copies of the inputs exist only for the checks below.
  logic [N_SRC-1:0]        pend_q;
  logic [N_SRC*PRIO_W-1:0] prio_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      prio_q <= '1;
    end else begin
      pend_q <= pend_i;
      prio_q <= prio_i;
    end
  end

  a_r5_idle_values: assert property (@(posedge clk) disable iff (rst)
    !found_o |-> (best_src_o == '0 && best_prio_o == '1));

  a_r4_mask_never_wins: assert property (@(posedge clk) disable iff (rst)
    found_o |-> best_prio_o != '1);

  a_r3_winner_was_pending: assert property (@(posedge clk) disable iff (rst)
    found_o |-> (pend_q[best_src_o] &&
                 prio_q[best_src_o*PRIO_W +: PRIO_W] == best_prio_o));

  a_r7_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!found_o && best_prio_o == '1));

  for (genvar s = 0; s < N_SRC; s++) begin : g_chk
    logic live;
    assign live = pend_q[s] && (prio_q[s*PRIO_W +: PRIO_W] != '1);

    a_r1_no_better_source: assert property (@(posedge clk) disable iff (rst)
      live |-> (found_o && best_prio_o <= prio_q[s*PRIO_W +: PRIO_W]));

    a_r2_lowest_index_tie: assert property (@(posedge clk) disable iff (rst)
      (live && found_o && prio_q[s*PRIO_W +: PRIO_W] == best_prio_o)
        |-> best_src_o <= SRC_W'(s));
  end
endmodule

// File: tb/irq_prio_select_test.sv
`timescale 1ns/1ps
module irq_prio_select_test;
  localparam int N  = 16;
  localparam int PW = 3;
  localparam int SW = 4;
  localparam logic [PW-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]    pend = '0;
  logic [N*PW-1:0] prio = '0;
  logic            found;
  logic [SW-1:0]   src;
  logic [PW-1:0]   pr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  irq_prio_select #(.N_SRC(N), .PRIO_W(PW)) uut (
    .clk(clk), .rst(rst), .pend_i(pend), .prio_i(prio),
    .found_o(found), .best_src_o(src), .best_prio_o(pr)
  );

  // Reference model: a linear scan keeping the strictly better candidate.
  task automatic expect_of(input logic [N-1:0] p, input logic [N*PW-1:0] q,
                           output logic ef, output logic [SW-1:0] es,
                           output logic [PW-1:0] ep);
    ef = 1'b0; es = '0; ep = MASK;
    for (int s = 0; s < N; s++) begin
      logic [PW-1:0] v;
      v = q[s*PW +: PW];
      if (p[s] && v != MASK && (!ef || v < ep)) begin
        ef = 1'b1; es = SW'(s); ep = v;
      end
    end
  endtask

  task automatic check(input string tag, input logic ef, input logic [SW-1:0] es,
                       input logic [PW-1:0] ep);
    checks++;
    if (found !== ef || src !== es || pr !== ep) begin
      fails++;
      $display("FAIL %s: got found=%0b src=%0d prio=%0d expected found=%0b src=%0d prio=%0d",
               tag, found, src, pr, ef, es, ep);
    end
  endtask

  // Drive on a falling edge; the rising edge registers; check on the next falling edge.
  task automatic apply(input string tag, input logic [N-1:0] p, input logic [N*PW-1:0] q);
    logic ef; logic [SW-1:0] es; logic [PW-1:0] ep;
    @(negedge clk);
    pend = p; prio = q;
    expect_of(p, q, ef, es, ep);
    @(negedge clk);
    check(tag, ef, es, ep);
  endtask

  function automatic logic [N*PW-1:0] all_prio(input logic [PW-1:0] v);
    logic [N*PW-1:0] r;
    for (int s = 0; s < N; s++) r[s*PW +: PW] = v;
    return r;
  endfunction

  initial begin
    logic [31:0] lfsr;
    logic [N*PW-1:0] q;
    // R7: the reset state.
    pend = '1; prio = '0;
    repeat (3) @(negedge clk);
    check("R7 reset idle", 1'b0, '0, MASK);
    rst = 1'b0;

    // R5: nothing is pending.
    apply("R5 none pending", '0, '0);
    // R4: every source is pending, but every field is masked.
    apply("R4 all masked", '1, all_prio(MASK));

    // R3/R4: each single source at each level.
    for (int s = 0; s < N; s++)
      for (int l = 0; l < (1 << PW); l++) begin
        q = all_prio(3'd0);
        q[s*PW +: PW] = PW'(l);
        apply(l == 7 ? "R4 single masked" : "R3 single source", N'(1) << s, q);
      end

    // R1/R2/R8: pairs of sources; each pair also gets a non-pending source at level 0.
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++) begin
        q = all_prio(MASK);
        q[a*PW +: PW] = PW'((a + b) % 3 + 2);
        q[b*PW +: PW] = PW'((a * b) % 3 + 2);
        q[((a + 1) % N)*PW +: PW] = (((a + 1) % N) == b) ? q[b*PW +: PW] : 3'd0;
        apply("R1 R2 R8 pair", (N'(1) << a) | (N'(1) << b), q);
      end

    // R2: every source is pending at one level.
    apply("R2 all tie", '1, all_prio(3'd4));
    // R8: a non-pending source at level 0 next to pending sources at level 5.
    q = all_prio(3'd5); q[0 +: PW] = 3'd0;
    apply("R8 non-pending better", 16'hFFFE, q);

    // R1/R2/R4/R8: pseudo-random pass with priorities drawn from a few levels.
    lfsr = 32'hACE1_2345;
    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] p;
      for (int s = 0; s < N; s++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        q[s*PW +: PW] = (k % 2 == 0) ? {1'b1, lfsr[1:0]} : lfsr[2:0];
      end
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      p = lfsr[15:0] & ((k % 3 == 0) ? lfsr[31:16] : 16'hFFFF);
      apply("R1 R2 R4 R8 random", p, q);
    end

    // R6: back-to-back changes, checked every cycle.
    for (int k = 0; k < N; k++) begin
      logic ef; logic [SW-1:0] es; logic [PW-1:0] ep;
      @(negedge clk);
      if (k > 0) begin
        expect_of(pend, prio, ef, es, ep);
        check("R6 one-cycle latency", ef, es, ep);
      end
      pend = N'(1) << (N - 1 - k);
      prio = all_prio(PW'(k % 7));
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule